// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits between a host and a byte-wide asynchronous NOR flash device. The device is driven through active-low chip-enable, write-enable and output-enable strobes, an address bus, and a data bus that is split into an output half, an output-enable and an input half. The host asks for one of four operations: a plain read, a byte program, an erase of a chosen set of sectors, or an erase of the whole chip. Each bus write and bus read is timed by clock-cycle counters. These counts are set by parameters and are derived from the device's nanosecond limits at the system clock period.

For a program or an erase, the block issues the unlock and command writes in order. It then polls the target location with repeated read cycles. Bit 7 of the read data shows the complement of the expected value while the device's embedded operation runs, and shows the true value once the operation is finished. The block stops polling on the first match. It reports `error` instead if a per-operation timeout runs out.

The request side is a valid/ready input. `req_ready` is high only while the sequencer is idle. A request is taken on the clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low, the host must hold the request fields steady. Completion is a one-cycle pulse on `done` or on `error`, never both, and `busy` covers the whole operation.

Top module: `flash_cmd_seq`

## Requirements
- R1: During reset and after it, all three strobes are high, the data bus is not driven, `req_ready` is 1 and `busy` is 0.
- R2: Every bus write holds write-enable low for exactly WE_LO clocks, with chip-enable low and data driven. Data stays driven into the following high phase. Write-enable stays high at least WE_HI clocks between writes, and write-enable and output-enable are never low together.
- R3: A read request (`req_op`=0) produces one read cycle at `req_addr`, with output-enable and chip-enable low for exactly RD_CYC clocks. `rd_data` holds the byte present on the bus at the end of that window when `done` pulses.
- R4: A program request (`req_op`=1) writes AAh@5555h, 55h@2AAAh, A0h@5555h and then `req_data`@`req_addr`, in that order.
- R5: A chip erase (`req_op`=3) writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh and then 10h@5555h.
- R6: A sector erase (`req_op`=2) writes the same first five bytes as R5. It then writes one 30h for each set bit of `req_sect`, in ascending sector index. Each of these goes to address index·2^(ADDR_W−log2 NSECT).
- R7: A sector erase with `req_sect`=0 produces no bus cycle and pulses `error` on the cycle after acceptance.
- R8: After the last 30h write of a sector erase, all strobes stay high for exactly WE_HI+ACC_CYC+1 clocks before the first poll read. After a program or chip erase the gap is WE_HI+1 clocks.
- R9: Polling reads the last written target address (program address, highest erased sector base, or 5555h for a chip erase). It ends with `done` on the first read whose bit 7 equals the expected value: `req_data` bit 7 for a program, 1 for an erase.
- R10: If the poll has not matched within the operation's timeout, `error` pulses with no `done`, and the block returns to idle with all strobes high.
- R11: Once a request is accepted, `req_ready` is low and `busy` is high until the cycle on which `done` or `error` pulses. `done` and `error` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken this edge if valid |
| req_op | input | 2 | 0 read, 1 program, 2 sector erase, 3 chip erase |
| req_addr | input | ADDR_W | Read or program address |
| req_data | input | 8 | Program byte |
| req_sect | input | NSECT | Sectors to erase, one bit per sector |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| error | output | 1 | One-cycle pulse on timeout or empty sector set |
| rd_data | output | 8 | Byte from the most recent read cycle |
| f_addr | output | ADDR_W | Flash address bus |
| f_dq_out | output | 8 | Flash data out |
| f_dq_oe | output | 1 | Drive enable for f_dq_out |
| f_dq_in | input | 8 | Flash data in |
| f_ce_n | output | 1 | Flash chip enable, active low |
| f_we_n | output | 1 | Flash write enable, active low |
| f_oe_n | output | 1 | Flash output enable, active low |

## Verification
Each command is visible at the pins as soon as it is issued. A wrong step counter or mask update therefore shows up within one write cycle as a misplaced byte or address in the recorded write stream, and the sweep over all nonzero sector sets catches any ordering slip. A wrong accept-window or poll-decision state shows up on the very first poll read, as an exact gap mismatch or a wrong count of poll reads. A faulty timeout counter only becomes visible after the timeout has run, as an `error` that arrives late or never.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    OP_READ = 2'd0,
    OP_PROG = 2'd1,
    OP_SECT = 2'd2,
    OP_CHIP = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    B_IDLE, B_WLO, B_WHI, B_RLO, B_RHZ
  } bus_st_e;

  typedef enum logic [2:0] {
    T_IDLE, T_ISSUE, T_WAITW, T_ACCEPT, T_PISSUE, T_PWAIT, T_RISSUE, T_RWAIT
  } top_st_e;

  localparam logic [15:0] KEY_ADDR_A = 16'h5555;
  localparam logic [15:0] KEY_ADDR_B = 16'h2AAA;
  localparam logic [7:0]  KEY_BYTE_A = 8'hAA;
  localparam logic [7:0]  KEY_BYTE_B = 8'h55;
  localparam logic [7:0]  CMD_PROG   = 8'hA0;
  localparam logic [7:0]  CMD_ERASE  = 8'h80;
  localparam logic [7:0]  CMD_CHIP   = 8'h10;
  localparam logic [7:0]  CMD_SECT   = 8'h30;

endpackage

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int WE_LO  = 4,
  parameter int WE_HI  = 2,
  parameter int RD_CYC = 6,
  parameter int RF_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_read,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic [7:0]        dq_in,
  output logic              ce_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        dq_out,
  output logic              dq_oe,
  output logic [7:0]        rdata,
  output logic              idle,
  output logic              last
);

  localparam int MAX_AB = (WE_LO > WE_HI) ? WE_LO : WE_HI;
  localparam int MAX_CD = (RD_CYC > RF_CYC) ? RD_CYC : RF_CYC;
  localparam int MAXC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CW     = $clog2(MAXC + 1);

  bus_st_e         st;
  logic [CW-1:0]   cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]      data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= B_IDLE;
      cnt    <= '0;
      addr_q <= '0;
      data_q <= '0;
      rdata  <= '0;
    end else begin
      case (st)
        B_IDLE: if (start) begin
          addr_q <= addr;
          data_q <= wdata;
          st     <= is_read ? B_RLO : B_WLO;
          cnt    <= is_read ? CW'(RD_CYC - 1) : CW'(WE_LO - 1);
        end
        B_WLO: if (cnt == '0) begin
          st  <= B_WHI;
          cnt <= CW'(WE_HI - 1);
        end else cnt <= cnt - 1'b1;
        B_WHI: if (cnt == '0) st <= B_IDLE;
               else cnt <= cnt - 1'b1;
        B_RLO: if (cnt == '0) begin
          rdata <= dq_in;
          st    <= B_RHZ;
          cnt   <= CW'(RF_CYC - 1);
        end else cnt <= cnt - 1'b1;
        B_RHZ: if (cnt == '0) st <= B_IDLE;
               else cnt <= cnt - 1'b1;
        default: st <= B_IDLE;
      endcase
    end
  end

  assign ce_n     = !(st == B_WLO || st == B_RLO);
  assign we_n     = (st != B_WLO);
  assign oe_n     = (st != B_RLO);
  assign dq_oe    = (st == B_WLO || st == B_WHI);
  assign bus_addr = addr_q;
  assign dq_out   = data_q;
  assign idle     = (st == B_IDLE);
  assign last     = (st == B_WHI || st == B_RHZ) && (cnt == '0);

  // Checker counters: length of each strobe-low run
  logic [CW:0] lo_w, lo_r;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_w <= '0;
      lo_r <= '0;
    end else begin
      lo_w <= we_n ? '0 : lo_w + 1'b1;
      lo_r <= oe_n ? '0 : lo_r + 1'b1;
    end
  end

  AST_WE_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (int'(lo_w) == WE_LO)); // R2
  AST_OE_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_n) |-> (int'(lo_r) == RD_CYC)); // R3
  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> idle); // R2

endmodule

// File: rtl/flash_cmd_gen.sv
module flash_cmd_gen
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int NSECT  = 8
) (
  input  op_e               op,
  input  logic [2:0]        step,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  input  logic [NSECT-1:0]  mask,
  output logic [ADDR_W-1:0] c_addr,
  output logic [7:0]        c_data,
  output logic              c_last
);

  localparam int IW      = (NSECT > 1) ? $clog2(NSECT) : 1;
  localparam int SECT_SH = ADDR_W - IW;

  logic [IW-1:0]    low_idx;
  logic [NSECT-1:0] rest;
  logic [ADDR_W-1:0] sect_base;

  always_comb begin
    low_idx = '0;
    for (int i = NSECT - 1; i >= 0; i--) begin
      if (mask[i]) low_idx = IW'(i);
    end
  end

  assign rest      = mask & (mask - 1'b1);
  assign sect_base = {low_idx, {SECT_SH{1'b0}}};

  always_comb begin
    c_last = 1'b0;
    c_addr = ADDR_W'(KEY_ADDR_A);
    c_data = KEY_BYTE_A;
    if (op == OP_PROG) begin
      case (step)
        3'd0: begin c_addr = ADDR_W'(KEY_ADDR_A); c_data = KEY_BYTE_A; end
        3'd1: begin c_addr = ADDR_W'(KEY_ADDR_B); c_data = KEY_BYTE_B; end
        3'd2: begin c_addr = ADDR_W'(KEY_ADDR_A); c_data = CMD_PROG;   end
        default: begin c_addr = addr; c_data = data; c_last = 1'b1; end
      endcase
    end else begin
      case (step)
        3'd0: begin c_addr = ADDR_W'(KEY_ADDR_A); c_data = KEY_BYTE_A; end
        3'd1: begin c_addr = ADDR_W'(KEY_ADDR_B); c_data = KEY_BYTE_B; end
        3'd2: begin c_addr = ADDR_W'(KEY_ADDR_A); c_data = CMD_ERASE;  end
        3'd3: begin c_addr = ADDR_W'(KEY_ADDR_A); c_data = KEY_BYTE_A; end
        3'd4: begin c_addr = ADDR_W'(KEY_ADDR_B); c_data = KEY_BYTE_B; end
        default: begin
          if (op == OP_CHIP) begin
            c_addr = ADDR_W'(KEY_ADDR_A);
            c_data = CMD_CHIP;
            c_last = 1'b1;
          end else begin
            c_addr = sect_base;
            c_data = CMD_SECT;
            c_last = (rest == '0);
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/flash_poll_timer.sv
module flash_poll_timer
  import flash_seq_pkg::*;
#(
  parameter int               TMO_W    = 40,
  parameter logic [TMO_W-1:0] TMO_PROG = 40'd20_000,
  parameter logic [TMO_W-1:0] TMO_SECT = 40'd4_000_000_000,
  parameter logic [TMO_W-1:0] TMO_CHIP = 40'd15_000_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  op_e  op,
  output logic hit
);

  logic [TMO_W-1:0] cnt, limit;

  always_comb begin
    case (op)
      OP_PROG: limit = TMO_PROG;
      OP_CHIP: limit = TMO_CHIP;
      default: limit = TMO_SECT;
    endcase
  end

  assign hit = (cnt >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else if (!hit) cnt <= cnt + 1'b1;
  end

  AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && run) |=> hit); // R10

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int               ADDR_W   = 19,
  parameter int               NSECT    = 8,
  parameter int               WE_LO    = 4,
  parameter int               WE_HI    = 2,
  parameter int               RD_CYC   = 6,
  parameter int               RF_CYC   = 2,
  parameter int               ACC_CYC  = 5000,
  parameter int               TMO_W    = 40,
  parameter logic [TMO_W-1:0] TMO_PROG = 40'd20_000,
  parameter logic [TMO_W-1:0] TMO_SECT = 40'd4_000_000_000,
  parameter logic [TMO_W-1:0] TMO_CHIP = 40'd15_000_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  input  logic [NSECT-1:0]  req_sect,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] f_addr,
  output logic [7:0]        f_dq_out,
  output logic              f_dq_oe,
  input  logic [7:0]        f_dq_in,
  output logic              f_ce_n,
  output logic              f_we_n,
  output logic              f_oe_n
);

  localparam int AW_CNT = $clog2(ACC_CYC + 1);

  top_st_e             st;
  op_e                 op_q;
  logic [ADDR_W-1:0]   addr_q, poll_addr;
  logic [7:0]          data_q;
  logic [NSECT-1:0]    mask_q;
  logic [2:0]          step;
  logic [AW_CNT-1:0]   acc_cnt;

  logic [ADDR_W-1:0]   c_addr, b_addr;
  logic [7:0]          c_data, b_rdata;
  logic                c_last, b_start, b_read, b_idle, b_last;
  logic                tmo_hit, tmo_run, exp7;

  flash_cmd_gen #(.ADDR_W(ADDR_W), .NSECT(NSECT)) u_gen (
    .op(op_q), .step(step), .addr(addr_q), .data(data_q), .mask(mask_q),
    .c_addr(c_addr), .c_data(c_data), .c_last(c_last)
  );

  assign b_start = (st == T_ISSUE) || (st == T_PISSUE) || (st == T_RISSUE);
  assign b_read  = (st != T_ISSUE);
  assign b_addr  = (st == T_ISSUE)  ? c_addr :
                   (st == T_PISSUE) ? poll_addr : addr_q;

  flash_bus_cycle #(
    .ADDR_W(ADDR_W), .WE_LO(WE_LO), .WE_HI(WE_HI),
    .RD_CYC(RD_CYC), .RF_CYC(RF_CYC)
  ) u_bus (
    .clk(clk), .rst_n(rst_n), .start(b_start), .is_read(b_read),
    .addr(b_addr), .wdata(c_data), .dq_in(f_dq_in),
    .ce_n(f_ce_n), .we_n(f_we_n), .oe_n(f_oe_n), .bus_addr(f_addr),
    .dq_out(f_dq_out), .dq_oe(f_dq_oe), .rdata(b_rdata),
    .idle(b_idle), .last(b_last)
  );

  assign tmo_run = (st == T_PISSUE) || (st == T_PWAIT);

  flash_poll_timer #(
    .TMO_W(TMO_W), .TMO_PROG(TMO_PROG), .TMO_SECT(TMO_SECT), .TMO_CHIP(TMO_CHIP)
  ) u_tmo (
    .clk(clk), .rst_n(rst_n), .run(tmo_run), .op(op_q), .hit(tmo_hit)
  );

  assign exp7      = (op_q == OP_PROG) ? data_q[7] : 1'b1;
  assign req_ready = (st == T_IDLE);
  assign busy      = (st != T_IDLE);
  assign rd_data   = b_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= T_IDLE;
      op_q      <= OP_READ;
      addr_q    <= '0;
      data_q    <= '0;
      mask_q    <= '0;
      step      <= '0;
      acc_cnt   <= '0;
      poll_addr <= '0;
      done      <= 1'b0;
      error     <= 1'b0;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      case (st)
        T_IDLE: if (req_valid) begin
          op_q   <= op_e'(req_op);
          addr_q <= req_addr;
          data_q <= req_data;
          mask_q <= req_sect;
          step   <= '0;
          case (op_e'(req_op))
            OP_READ: st <= T_RISSUE;
            OP_SECT: if (req_sect == '0) error <= 1'b1;
                     else st <= T_ISSUE;
            default: st <= T_ISSUE;
          endcase
        end
        T_ISSUE: st <= T_WAITW;
        T_WAITW: if (b_last) begin
          if (c_last) begin
            poll_addr <= c_addr;
            acc_cnt   <= '0;
            st        <= (op_q == OP_SECT) ? T_ACCEPT : T_PISSUE;
          end else begin
            if (step != 3'd5) step <= step + 1'b1;
            if (op_q == OP_SECT && step == 3'd5) mask_q <= mask_q & (mask_q - 1'b1);
            st <= T_ISSUE;
          end
        end
        T_ACCEPT: if (acc_cnt == AW_CNT'(ACC_CYC - 1)) st <= T_PISSUE;
                  else acc_cnt <= acc_cnt + 1'b1;
        T_PISSUE: st <= T_PWAIT;
        T_PWAIT: if (b_last) begin
          if (b_rdata[7] == exp7) begin
            done <= 1'b1;
            st   <= T_IDLE;
          end else if (tmo_hit) begin
            error <= 1'b1;
            st    <= T_IDLE;
          end else st <= T_PISSUE;
        end
        T_RISSUE: st <= T_RWAIT;
        T_RWAIT: if (b_last) begin
          done <= 1'b1;
          st   <= T_IDLE;
        end
        default: st <= T_IDLE;
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (f_ce_n && f_we_n && f_oe_n && !f_dq_oe)); // R11
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error)); // R11
  AST_ACCEPT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == T_ACCEPT) |-> (f_we_n && f_oe_n)); // R8
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (error && $past(st) != T_IDLE) |-> $past(tmo_hit)); // R10
  AST_POLL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(st) == T_PWAIT) |-> (b_rdata[7] == exp7)); // R9

endmodule

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;

  localparam int AW  = 19;
  localparam int NS  = 8;
  localparam int WLO = 4;
  localparam int WHI = 2;
  localparam int RDC = 6;
  localparam int RFC = 2;
  localparam int ACC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_data = '0;
  logic [NS-1:0] req_sect = '0;
  logic          busy, done, error;
  logic [7:0]    rd_data;
  logic [AW-1:0] f_addr;
  logic [7:0]    f_dq_out, f_dq_in;
  logic          f_dq_oe, f_ce_n, f_we_n, f_oe_n;

  flash_cmd_seq #(
    .ADDR_W(AW), .NSECT(NS), .WE_LO(WLO), .WE_HI(WHI), .RD_CYC(RDC),
    .RF_CYC(RFC), .ACC_CYC(ACC), .TMO_W(40),
    .TMO_PROG(40'd400), .TMO_SECT(40'd3000), .TMO_CHIP(40'd3000)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .req_sect(req_sect),
    .busy(busy), .done(done), .error(error), .rd_data(rd_data),
    .f_addr(f_addr), .f_dq_out(f_dq_out), .f_dq_oe(f_dq_oe), .f_dq_in(f_dq_in),
    .f_ce_n(f_ce_n), .f_we_n(f_we_n), .f_oe_n(f_oe_n)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // Flash model
  int   busy_cfg = 0;
  int   busy_left = 0;
  logic mdl_active = 1'b0;
  logic mdl_exp7 = 1'b0;
  assign f_dq_in = (!f_ce_n && !f_oe_n) ?
                   (mdl_active ? ((busy_left > 0) ? {~mdl_exp7, 7'h2A} : {mdl_exp7, 7'h15})
                               : pat(f_addr)) : 8'h00;

  logic [AW-1:0] log_a [16];
  logic [7:0]    log_d [16];
  int   log_n = 0, rd_n = 0, gap_first = 0, idle_run = 0, we_run = 0, oe_run = 0;
  logic [AW-1:0] rd_addr = '0;
  logic prev_we = 1'b1, prev_oe = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!f_we_n && !f_oe_n) chk(0, "R2 we/oe overlap", 1, 0);
      if (!f_we_n && (f_ce_n || !f_dq_oe)) chk(0, "R2 ce/data during write", {f_ce_n, f_dq_oe}, 2'b01);
      if (!prev_we && f_we_n) begin
        chk(we_run == WLO, "R2 we low width", we_run, WLO);
        chk(f_dq_oe, "R2 data hold", f_dq_oe, 1);
        if (log_n < 16) begin
          log_a[log_n] = f_addr;
          log_d[log_n] = f_dq_out;
        end
        log_n++;
        busy_left = busy_cfg;
        we_run = 0;
      end
      if (prev_we && !f_we_n && log_n > 0)
        chk(idle_run >= WHI, "R2 we high width", idle_run, WHI);
      if (prev_oe && !f_oe_n) begin
        if (rd_n == 0) gap_first = idle_run;
        rd_n++;
        rd_addr = f_addr;
      end
      if (!prev_oe && f_oe_n) begin
        chk(oe_run == RDC, "R3 oe low width", oe_run, RDC);
        oe_run = 0;
        if (busy_left > 0) busy_left--;
      end
      if (!f_we_n) we_run++;
      if (!f_oe_n) oe_run++;
      if (f_we_n && f_oe_n) idle_run++; else idle_run = 0;
      prev_we = f_we_n;
      prev_oe = f_oe_n;
    end
  end

  logic [AW-1:0] ex_a [16];
  logic [7:0]    ex_d [16];
  int ex_n;

  task automatic cmp_log(input string tag);
    chk(log_n == ex_n, {tag, " write count"}, log_n, ex_n);
    for (int i = 0; i < ex_n && i < 16; i++) begin
      chk(log_a[i] == ex_a[i], {tag, " write addr"}, log_a[i], ex_a[i]);
      chk(log_d[i] == ex_d[i], {tag, " write data"}, log_d[i], ex_d[i]);
    end
  endtask

  task automatic push(input logic [AW-1:0] a, input logic [7:0] d);
    ex_a[ex_n] = a;
    ex_d[ex_n] = d;
    ex_n++;
  endtask

  task automatic push_unlock5();
    push(19'h5555, 8'hAA); push(19'h2AAA, 8'h55); push(19'h5555, 8'h80);
    push(19'h5555, 8'hAA); push(19'h2AAA, 8'h55);
  endtask

  task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                        input logic [NS-1:0] m, output bit gd, output bit ge, output bit acc_ok);
    int w;
    @(negedge clk);
    log_n = 0; rd_n = 0; gap_first = -1; ex_n = 0;
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d; req_sect = m;
    @(negedge clk);
    req_valid = 1'b0;
    acc_ok = busy && !req_ready;
    gd = 0; ge = 0; w = 0;
    while (!gd && !ge && w < 20000) begin
      if (done) gd = 1;
      if (error) ge = 1;
      if (done && error) chk(0, "R11 done and error together", 1, 0);
      if (!gd && !ge) begin
        if (!busy || req_ready) begin
          chk(0, "R11 busy dropped early", {busy, req_ready}, 2'b10);
          w = 20000;
        end
        @(negedge clk);
        w++;
      end
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    bit gd, ge, ak;
    logic [AW-1:0] a;
    logic [7:0] d;
    int hi;
    repeat (3) @(negedge clk);
    chk(f_ce_n && f_we_n && f_oe_n && !f_dq_oe, "R1 strobes in reset", {f_ce_n, f_we_n, f_oe_n, f_dq_oe}, 4'b1110);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(f_ce_n && f_we_n && f_oe_n && !f_dq_oe, "R1 strobes after reset", {f_ce_n, f_we_n, f_oe_n, f_dq_oe}, 4'b1110);
    chk(req_ready && !busy, "R1 ready idle", {req_ready, busy}, 2'b10);

    // R3: plain reads
    mdl_active = 1'b0;
    for (int i = 0; i < 8; i++) begin
      a = AW'(i * 32'h0F1E3 + 7);
      run_op(2'd0, a, 8'h00, '0, gd, ge, ak);
      chk(gd && !ge, "R3 read done", {gd, ge}, 2'b10);
      chk(rd_data == pat(a), "R3 read data", rd_data, pat(a));
      chk(rd_n == 1 && log_n == 0, "R3 single read cycle", rd_n, 1);
      chk(ak, "R11 busy after accept", ak, 1);
    end

    // R4/R9: program sweep
    mdl_active = 1'b1;
    for (int i = 0; i < 16; i++) begin
      a = AW'(i * 32'h12345 + 3);
      d = 8'(i * 17 + 5);
      busy_cfg = i % 3;
      mdl_exp7 = d[7];
      run_op(2'd1, a, d, '0, gd, ge, ak);
      ex_n = 0;
      push(19'h5555, 8'hAA); push(19'h2AAA, 8'h55); push(19'h5555, 8'hA0); push(a, d);
      cmp_log("R4 program");
      chk(gd && !ge, "R9 program done", {gd, ge}, 2'b10);
      chk(rd_n == busy_cfg + 1, "R9 poll reads", rd_n, busy_cfg + 1);
      chk(rd_addr == a, "R9 poll addr", rd_addr, a);
      chk(gap_first == WHI + 1, "R8 program gap", gap_first, WHI + 1);
      chk(ak, "R11 busy after accept", ak, 1);
    end

    // R6/R8: all nonzero sector sets
    mdl_exp7 = 1'b1;
    for (int m = 1; m < 256; m++) begin
      busy_cfg = m % 4;
      run_op(2'd2, '0, 8'h00, NS'(m), gd, ge, ak);
      ex_n = 0;
      push_unlock5();
      hi = 0;
      for (int s = 0; s < NS; s++) if (m[s]) begin
        push(AW'(s) << 16, 8'h30);
        hi = s;
      end
      cmp_log("R6 sector erase");
      chk(gd && !ge, "R9 sector done", {gd, ge}, 2'b10);
      chk(rd_n == busy_cfg + 1, "R9 sector poll reads", rd_n, busy_cfg + 1);
      chk(rd_addr == (AW'(hi) << 16), "R9 sector poll addr", rd_addr, AW'(hi) << 16);
      chk(gap_first == WHI + ACC + 1, "R8 accept window", gap_first, WHI + ACC + 1);
    end

    // R5: chip erase
    busy_cfg = 3;
    run_op(2'd3, '0, 8'h00, '0, gd, ge, ak);
    ex_n = 0;
    push_unlock5();
    push(19'h5555, 8'h10);
    cmp_log("R5 chip erase");
    chk(gd && !ge, "R9 chip done", {gd, ge}, 2'b10);
    chk(rd_n == 4, "R9 chip poll reads", rd_n, 4);
    chk(rd_addr == 19'h5555, "R9 chip poll addr", rd_addr, 19'h5555);
    chk(gap_first == WHI + 1, "R8 chip gap", gap_first, WHI + 1);

    // R7: empty sector set
    run_op(2'd2, '0, 8'h00, '0, gd, ge, ak);
    chk(ge && !gd, "R7 empty mask error", {gd, ge}, 2'b01);
    repeat (3) @(negedge clk);
    chk(log_n == 0 && rd_n == 0, "R7 no bus cycles", log_n + rd_n, 0);

    // R10: timeout
    busy_cfg = 100000;
    mdl_exp7 = 1'b0;
    run_op(2'd1, 19'h00123, 8'h42, '0, gd, ge, ak);
    chk(ge && !gd, "R10 timeout error", {gd, ge}, 2'b01);
    chk(req_ready && f_ce_n && f_we_n && f_oe_n && !f_dq_oe, "R10 idle after timeout",
        {req_ready, f_ce_n, f_we_n, f_oe_n, f_dq_oe}, 5'b11110);
    chk(rd_n > 5, "R10 polled before timeout", rd_n, 6);
    @(negedge clk);
    busy_left = 0;
    busy_cfg = 0;

    // R3 recovery read
    mdl_active = 1'b0;
    run_op(2'd0, 19'h3C0F0, 8'h00, '0, gd, ge, ak);
    chk(gd && rd_data == pat(19'h3C0F0), "R3 read after timeout", rd_data, pat(19'h3C0F0));

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule